// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block gathers the three interrupt sources of a PC-style real-time clock: a periodic tick, an alarm match and an end-of-update event. It turns them into one active-high interrupt line. The alarm comparator and the calendar counters sit outside the block and each delivers a one-cycle event pulse. The periodic tick is made here. A power-of-two divider counts enable pulses from a 32.768 kHz reference and is set by a 4-bit rate code.

Software sees three byte registers through a read/write strobe port: the rate code, a control byte that holds the three enables, and a status byte that holds the three event flags plus a summary bit. A flag records its event even when its enable is off. The summary bit and the interrupt line follow only the flags whose enable is set. Reading the status byte returns its contents and clears every flag, which acknowledges the interrupt. An event that lands on the same cycle as that read is kept.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the rate code reads 6, the control byte reads 0x00, the status byte reads 0x00, and `irq` is low.
- R2: Register address 0 holds the rate code in bits 3:0, and bits 7:4 read as 0. Address 1 holds the enables in bits 6 (periodic), 5 (alarm) and 4 (update), and its other bits read as 0. Address 2 is the status byte: bit 7 is the summary, and bits 6, 5 and 4 are the periodic, alarm and update flags. Read data appears on `rd_data` in the cycle after the read strobe. Address 3 reads 0.
- R3: An event pulse sets its flag whether or not its enable is set.
- R4: The summary bit and `irq` are high exactly when at least one flag is set together with its enable. `irq` changes in the cycle after the event pulse or the control write that causes the change.
- R5: A read of address 2 returns the status as it stood before the read. It also clears all three flags and the summary bit, so `irq` is low in the following cycle.
- R6: An event pulse in the same cycle as a read of address 2 is not lost. The read returns the status without that event, and the flag is set afterwards.
- R7: A rate code n from 1 to 15 gives one periodic event every 2^(n-1) reference pulses, which is 2^(16-n) Hz from 32.768 kHz. Counting restarts when the rate code is written. Code 0 gives no periodic events.
- R8: If the alarm enable is cleared and the status byte is then read, setting the alarm enable again leaves `irq` low until a new alarm pulse arrives.
- R9: A write to address 2 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_data | output | 8 | Registered read data |
| ref_tick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | End-of-update pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
The status-register read and the arrival of an event pulse can fall on the same clock edge. The read clears the flags while the event sets one. The bench raises the read strobe and an alarm pulse in the same cycle, with the alarm enabled and an update flag already pending. It expects the read to return only the earlier update flag, expects `irq` to go high in the next cycle, and expects a second read to return the alarm flag together with the summary bit.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NSRC     = 3;   // periodic, alarm, update
  localparam int SRC_UPD  = 0;
  localparam int SRC_ALM  = 1;
  localparam int SRC_PER  = 2;
  localparam int FLAG_LSB = 4;   // sources occupy bits 4..6 of both registers
  localparam int SUM_BIT  = 7;

  localparam logic [1:0] ADR_RATE = 2'd0;
  localparam logic [1:0] ADR_CTRL = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [RATE_W-1:0] rate,
  input  logic              rate_wr,
  output logic              per_evt
);
  localparam int CNT_W = (1 << RATE_W) - 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    if (rate == '0) mask = '0;
    else            mask = ~({CNT_W{1'b1}} << (rate - 1'b1));
  end

  assign per_evt = ref_tick && (rate != '0) && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || rate_wr) cnt <= '0;
    else if (ref_tick)  cnt <= cnt + 1'b1;
  end

  // R7: a rate slower than one per reference pulse never yields back-to-back events
  a_r7_event_spacing: assert property (@(posedge clk) disable iff (rst)
    (per_evt && rate > 1 && !rate_wr) |=> !per_evt);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en_next,
  input  logic            rd_clr,
  output logic [NSRC-1:0] flags,
  output logic            summary
);
  logic [NSRC-1:0] flags_nxt;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    assign flags_nxt[i] = (flags[i] & ~rd_clr) | evt[i];
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= flags_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) summary <= 1'b0;
    else     summary <= |(flags_nxt & en_next);
  end

  // R3: every pulsed source shows its flag one cycle later
  a_r3_event_latches: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  // R5: a read with no coincident event leaves nothing pending
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && evt == '0) |=> (flags == '0 && !summary));
  // R6: an event that meets a read survives it
  a_r6_collision_kept: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && (|evt)) |=> (flags == $past(evt)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int RATE_W     = 4,
  parameter int RATE_RESET = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       ref_tick,
  input  logic       alarm_evt,
  input  logic       update_evt,
  output logic       irq
);
  import rtc_irq_pkg::*;

  logic [RATE_W-1:0] rate_q;
  logic [NSRC-1:0]   en_q, en_nxt;
  logic [NSRC-1:0]   flags, evt;
  logic              summary, per_evt;
  logic              rate_wr, ctrl_wr, stat_rd;
  logic [7:0]        rd_mux;
  logic              unused_wr_bit;

  assign unused_wr_bit = wr_data[SUM_BIT];

  assign rate_wr = wr_en && (addr == ADR_RATE);
  assign ctrl_wr = wr_en && (addr == ADR_CTRL);
  assign stat_rd = rd_en && (addr == ADR_STAT);
  assign en_nxt  = ctrl_wr ? wr_data[FLAG_LSB +: NSRC] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RATE_W'(RATE_RESET);
      en_q   <= '0;
    end else begin
      if (rate_wr) rate_q <= wr_data[RATE_W-1:0];
      en_q <= en_nxt;
    end
  end

  rtc_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .ref_tick(ref_tick),
    .rate(rate_q), .rate_wr(rate_wr), .per_evt(per_evt)
  );

  always_comb begin
    evt = '0;
    evt[SRC_PER] = per_evt;
    evt[SRC_ALM] = alarm_evt;
    evt[SRC_UPD] = update_evt;
  end

  rtc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt), .en_next(en_nxt),
    .rd_clr(stat_rd), .flags(flags), .summary(summary)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_RATE: rd_mux[RATE_W-1:0] = rate_q;
      ADR_CTRL: rd_mux[FLAG_LSB +: NSRC] = en_q;
      ADR_STAT: begin
        rd_mux[FLAG_LSB +: NSRC] = flags;
        rd_mux[SUM_BIT]          = summary;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign irq = summary;

  // R4: with every enable clear the line stays low
  a_r4_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq);
  // R4: a raised line always has an enabled pending flag behind it
  a_r4_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((flags & en_q) != '0));
  // R9: a status write without events or reads changes no flag
  a_r9_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_STAT && !rd_en && evt == '0) |=> $stable(flags));
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       ref_tick = 1'b0;
  logic       alarm_evt = 1'b0;
  logic       update_evt = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  always #5 clk = ~clk;

  rtc_irq_ctrl u_rtc_irq_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ref_tick(ref_tick),
    .alarm_evt(alarm_evt), .update_evt(update_evt), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data when a read result becomes valid
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk(rd_data, 8'hxx, "unexpected read");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag,
                    input logic with_alarm = 1'b0);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); addr = a; rd_en = 1'b1; alarm_evt = with_alarm;
    @(negedge clk); rd_en = 1'b0; alarm_evt = 1'b0;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_evt = 1'b1;
    @(negedge clk); update_evt = 1'b0;
  endtask

  task automatic pulse_ref(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    #(10 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({7'd0, irq}, 8'h00, "R1 irq after reset");
    rd(2'd0, 8'h06, "R1 rate reset");
    rd(2'd1, 8'h00, "R1 ctrl reset");
    rd(2'd2, 8'h00, "R1 status reset");
    rd(2'd3, 8'h00, "R2 unused address");
    // R2 register layout
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h70, "R2 ctrl bits");
    wr(2'd0, 8'hA3);
    rd(2'd0, 8'h03, "R2 rate bits");
    wr(2'd1, 8'h00);
    // R3 flag latches with enable clear
    pulse_alarm();
    chk({7'd0, irq}, 8'h00, "R3 masked alarm keeps irq low");
    rd(2'd2, 8'h20, "R3 alarm flag latched");
    rd(2'd2, 8'h00, "R5 flags cleared by read");
    // R4 enabling a pending flag raises irq
    pulse_update();
    wr(2'd1, 8'h10);
    chk({7'd0, irq}, 8'h01, "R4 irq on enable write");
    rd(2'd2, 8'h90, "R4 summary with update");
    chk({7'd0, irq}, 8'h00, "R5 irq drops after read");
    pulse_update();
    chk({7'd0, irq}, 8'h01, "R4 irq after enabled event");
    rd(2'd2, 8'h90, "R5 read returns pending");
    // R6 collision of read and alarm event
    wr(2'd1, 8'h20);
    pulse_update();
    chk({7'd0, irq}, 8'h00, "R4 unenabled update no irq");
    rd(2'd2, 8'h10, "R6 read returns pre-event status", 1'b1);
    chk({7'd0, irq}, 8'h01, "R6 alarm kept after read");
    rd(2'd2, 8'hA0, "R6 alarm flag afterwards");
    chk({7'd0, irq}, 8'h00, "R6 irq cleared");
    // R8 stale alarm
    pulse_alarm();
    chk({7'd0, irq}, 8'h01, "R8 alarm irq");
    wr(2'd1, 8'h00);
    chk({7'd0, irq}, 8'h00, "R8 disable drops irq");
    rd(2'd2, 8'h20, "R8 flag read while disabled");
    wr(2'd1, 8'h20);
    chk({7'd0, irq}, 8'h00, "R8 no stale alarm");
    rd(2'd2, 8'h00, "R8 status empty");
    // R9 status writes ignored
    pulse_update();
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h10, "R9 status write ignored");
    wr(2'd2, 8'h00);
    pulse_update();
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h10, "R9 zero write does not clear");
    // R7 periodic divider
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    pulse_ref(3);
    rd(2'd2, 8'h00, "R7 rate 3 before 4th tick");
    pulse_ref(1);
    rd(2'd2, 8'h40, "R7 rate 3 on 4th tick");
    wr(2'd0, 8'h01);
    pulse_ref(1);
    rd(2'd2, 8'h40, "R7 rate 1 every tick");
    wr(2'd0, 8'h00);
    pulse_ref(20);
    rd(2'd2, 8'h00, "R7 rate 0 silent");
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h40);
    pulse_ref(1);
    chk({7'd0, irq}, 8'h00, "R7 rate 2 first tick");
    pulse_ref(1);
    chk({7'd0, irq}, 8'h01, "R7 rate 2 second tick");
    rd(2'd2, 8'hC0, "R7 periodic summary");
    wr(2'd0, 8'h0F);
    pulse_ref(16383);
    chk({7'd0, irq}, 8'h00, "R7 rate 15 before period");
    pulse_ref(1);
    chk({7'd0, irq}, 8'h01, "R7 rate 15 at period");
    rd(2'd2, 8'hC0, "R7 rate 15 flag");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "reads outstanding");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule